// File: doc/BRIEF.md
# Cascaded Programmable Clock Divider

This block derives a slow, symmetric output clock from a fast source clock. A chain of three stages sits in series. The first stage divides by a small odd factor. The second is a pair of programmable counters, one after the other. The third is a toggle flop that halves the rate once more, so the output always has a 50% duty cycle. Every stage before the toggle works as a one-cycle enable pulse in the source clock domain. Only the final flop drives the output clock, so no derived clock is created inside the block.

The three divisor fields are live inputs. The block copies them into its active settings at two points: the first source edge after reset, and each toggle of the output clock. A change therefore never cuts an output half-period short. A valid flag tells downstream logic when the output has completed a full period under the settings now in force.

Top module: `clkdiv_chain`

## Requirements
- R1: The odd stage divides by 2*c+1, where c is the 2-bit code on `odd_sel_i`: code 0 gives 1 (a pulse on every source cycle), 1 gives 3, 2 gives 5 and 3 gives 7.
- R2: The first counter divides by v+1, where v is the 6-bit value on `div_a_m1_i`, covering 1 to 64.
- R3: The second counter follows the first and divides by v+1, where v is the 8-bit value on `div_b_m1_i`, covering 1 to 256.
- R4: `clk_o` toggles once every H*L*X source cycles, where H, L and X are the three stage divisors. The output period is therefore 2*H*L*X cycles, and its high and low phases are equal.
- R5: When both counter fields are zero, the odd stage pulse drives the toggle directly, so `clk_o` toggles every H source cycles.
- R6: The active settings change only on the first source edge after reset or on a source edge where `clk_o` toggles. The half-period in progress when the inputs change finishes with the old settings.
- R7: While `rst_ni` is low, `clk_o` and `valid_o` are 0.
- R8: `valid_o` is 0 after reset and drops on any toggle that loads settings different from the active ones. It rises on the second toggle after that load, which is 2*H*L*X source cycles later with the new settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| odd_sel_i | input | 2 | Odd stage code c, divisor 2*c+1 |
| div_a_m1_i | input | 6 | First counter divisor minus one |
| div_b_m1_i | input | 8 | Second counter divisor minus one |
| clk_o | output | 1 | Divided output clock, 50% duty |
| valid_o | output | 1 | A full output period has completed under the active settings |

## Verification
A stuck or miscounting stage counter shows up on `clk_o` as a half-period that is too long or too short. This is visible at the very next output edge, so the bench measures every half-period in source cycles against H*L*X. A wrong load point in the settings register shows as a changed interval one toggle too early, and the mid-period reconfiguration cases catch it. A wrong valid tracking state shows as `valid_o` staying high across a change, or rising at some distance other than two half-periods after the load.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   localparam int unsigned ODD_SEL_W = 2;
   localparam int unsigned DEF_A_W   = 6;
   localparam int unsigned DEF_B_W   = 8;

   typedef enum logic [ODD_SEL_W-1:0] {
      ODD_DIV1 = 2'd0,
      ODD_DIV3 = 2'd1,
      ODD_DIV5 = 2'd2,
      ODD_DIV7 = 2'd3
   } odd_code_e;

   // last count value of the odd stage: divisor 2*c+1 counts 0..2*c
   function automatic logic [ODD_SEL_W:0] odd_last(input logic [ODD_SEL_W-1:0] code);
      return {code, 1'b0};
   endfunction

endpackage

// File: rtl/clkdiv_odd_stage.sv
module clkdiv_odd_stage
   import clkdiv_pkg::*;
#(
   parameter int unsigned SEL_W = ODD_SEL_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);

   localparam int unsigned CNT_W = SEL_W + 1;

   if (SEL_W != ODD_SEL_W) begin : g_bad_sel
      $error("clkdiv_odd_stage: SEL_W must equal ODD_SEL_W");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;

   assign last   = odd_last(sel_i);
   assign tick_o = run_i && (cnt_q == last);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (tick_o) begin
         cnt_q <= '0;
      end else if (run_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/clkdiv_count_stage.sv
module clkdiv_count_stage #(
   parameter int unsigned W = 6
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         tick_i,
   input  logic [W-1:0] last_i,
   output logic         tick_o
);

   if (W < 1 || W > 16) begin : g_bad_w
      $error("clkdiv_count_stage: W out of range 1..16");
   end

   logic [W-1:0] cnt_q;

   assign tick_o = tick_i && (cnt_q == last_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (tick_o) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/clkdiv_cfg_ctrl.sv
module clkdiv_cfg_ctrl
   import clkdiv_pkg::*;
#(
   parameter int unsigned A_W = DEF_A_W,
   parameter int unsigned B_W = DEF_B_W
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [ODD_SEL_W-1:0] sel_i,
   input  logic [A_W-1:0]       a_i,
   input  logic [B_W-1:0]       b_i,
   input  logic                 term_i,
   output logic                 run_o,
   output logic [ODD_SEL_W-1:0] sel_o,
   output logic [A_W-1:0]       a_o,
   output logic [B_W-1:0]       b_o,
   output logic                 load_o,
   output logic                 chg_o,
   output logic                 valid_o
);

   localparam int unsigned CFG_W = ODD_SEL_W + A_W + B_W;

   logic             run_q;
   logic [CFG_W-1:0] act_q;
   logic [CFG_W-1:0] nxt;
   logic [1:0]       half_q;
   logic             valid_q;

   assign nxt    = {sel_i, a_i, b_i};
   assign load_o = !run_q || term_i;
   assign chg_o  = load_o && (nxt != act_q);
   assign run_o  = run_q;
   assign {sel_o, a_o, b_o} = act_q;
   assign valid_o = valid_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q   <= 1'b0;
         act_q   <= '0;
         half_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         run_q <= 1'b1;
         if (load_o) begin
            act_q <= nxt;
         end
         if (chg_o) begin
            half_q  <= '0;
            valid_q <= 1'b0;
         end else if (term_i) begin
            if (half_q == 2'd1) begin
               valid_q <= 1'b1;
            end
            if (half_q != 2'd2) begin
               half_q <= half_q + 2'd1;
            end
         end
      end
   end

endmodule

// File: rtl/clkdiv_toggle_stage.sv
module clkdiv_toggle_stage (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   output logic clk_o
);

   logic tgl_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tgl_q <= 1'b0;
      end else if (tick_i) begin
         tgl_q <= !tgl_q;
      end
   end

   assign clk_o = tgl_q;

endmodule

// File: rtl/clkdiv_chain.sv
module clkdiv_chain
   import clkdiv_pkg::*;
#(
   parameter int unsigned A_W       = DEF_A_W,
   parameter int unsigned B_W       = DEF_B_W,
   parameter bit          BYPASS_EN = 1'b1
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic [ODD_SEL_W-1:0] odd_sel_i,
   input  logic [A_W-1:0]       div_a_m1_i,
   input  logic [B_W-1:0]       div_b_m1_i,
   output logic                 clk_o,
   output logic                 valid_o
);

   if (A_W < 1 || A_W > 16) begin : g_bad_a
      $error("clkdiv_chain: A_W out of range");
   end
   if (B_W < 1 || B_W > 16) begin : g_bad_b
      $error("clkdiv_chain: B_W out of range");
   end

   logic                 run;
   logic [ODD_SEL_W-1:0] sel_q;
   logic [A_W-1:0]       a_q;
   logic [B_W-1:0]       b_q;
   logic                 cfg_load;
   logic                 cfg_chg;
   logic                 odd_tick;
   logic                 a_tick;
   logic                 b_tick;
   logic                 fin_tick;
   logic                 bypass;

   clkdiv_cfg_ctrl #(.A_W(A_W), .B_W(B_W)) u_cfg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (odd_sel_i),
      .a_i     (div_a_m1_i),
      .b_i     (div_b_m1_i),
      .term_i  (fin_tick),
      .run_o   (run),
      .sel_o   (sel_q),
      .a_o     (a_q),
      .b_o     (b_q),
      .load_o  (cfg_load),
      .chg_o   (cfg_chg),
      .valid_o (valid_o)
   );

   clkdiv_odd_stage #(.SEL_W(ODD_SEL_W)) u_odd (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run),
      .sel_i  (sel_q),
      .tick_o (odd_tick)
   );

   clkdiv_count_stage #(.W(A_W)) u_cnt_a (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (odd_tick),
      .last_i (a_q),
      .tick_o (a_tick)
   );

   clkdiv_count_stage #(.W(B_W)) u_cnt_b (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (a_tick),
      .last_i (b_q),
      .tick_o (b_tick)
   );

   assign bypass = (a_q == '0) && (b_q == '0);

   if (BYPASS_EN) begin : g_bypass
      assign fin_tick = bypass ? odd_tick : b_tick;
   end else begin : g_cascade
      assign fin_tick = b_tick;
   end

   clkdiv_toggle_stage u_tgl (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (fin_tick),
      .clk_o  (clk_o)
   );

endmodule

// File: rtl/clkdiv_chain_chk.sv
module clkdiv_chain_chk
   import clkdiv_pkg::*;
#(
   parameter int unsigned A_W = DEF_A_W,
   parameter int unsigned B_W = DEF_B_W
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic                 odd_tick,
   input logic                 fin_tick,
   input logic                 bypass,
   input logic                 cfg_load,
   input logic                 cfg_chg,
   input logic [ODD_SEL_W-1:0] sel_q,
   input logic [A_W-1:0]       a_q,
   input logic [B_W-1:0]       b_q,
   input logic                 clk_o,
   input logic                 valid_o
);

   AST_ODD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (odd_tick && sel_q != '0 && !cfg_load) |=> !odd_tick); // R1

   AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fin_tick |=> $stable(clk_o)); // R4

   AST_FLIP_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fin_tick |=> (clk_o != $past(clk_o))); // R4

   AST_BYPASS_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bypass && odd_tick) |-> fin_tick); // R5

   AST_CFG_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_load |=> $stable({sel_q, a_q, b_q})); // R6

   AST_VALID_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_chg |=> !valid_o); // R8

   AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(valid_o) |-> $past(fin_tick)); // R8

endmodule

bind clkdiv_chain clkdiv_chain_chk #(.A_W(A_W), .B_W(B_W)) chk_i (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .odd_tick (odd_tick),
   .fin_tick (fin_tick),
   .bypass   (bypass),
   .cfg_load (cfg_load),
   .cfg_chg  (cfg_chg),
   .sel_q    (sel_q),
   .a_q      (a_q),
   .b_q      (b_q),
   .clk_o    (clk_o),
   .valid_o  (valid_o)
);

// File: tb/clkdiv_chain_tb_top.sv
module clkdiv_chain_tb_top;

   localparam int CLK_P = 10;
   localparam int WDOG  = 190000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] sel = '0;
   logic [5:0] da = '0;
   logic [7:0] db = '0;
   logic       clk_o;
   logic       valid_o;

   int tests = 0;
   int fails = 0;

   int    exp_q[$];
   string tag_q[$];

   always #(CLK_P/2) clk = !clk;

   clkdiv_chain dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .odd_sel_i  (sel),
      .div_a_m1_i (da),
      .div_b_m1_i (db),
      .clk_o      (clk_o),
      .valid_o    (valid_o)
   );

   // monitor: measures every half-period of clk_o in source cycles
   int   cyc = 0;
   int   last_cyc = 0;
   logic prev_o = 1'b0;
   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         last_cyc = cyc;
         prev_o   = clk_o;
      end else if (clk_o !== prev_o) begin
         if (exp_q.size() > 0) begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            tests++;
            if (cyc - last_cyc != e) begin
               fails++;
               $display("FAIL %s half-period got %0d exp %0d", t, cyc - last_cyc, e);
            end
         end
         last_cyc = cyc;
         prev_o   = clk_o;
      end
   end

   task automatic step();
      @(posedge clk);
      #(CLK_P/4);
   endtask

   task automatic check(input string t, input int got, input int exp);
      tests++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s got %0d exp %0d", t, got, exp);
      end
   endtask

   function automatic int half_of(input int s, input int a, input int b);
      return (2*s + 1) * (a + 1) * (b + 1);
   endfunction

   task automatic push(input int n, input string t);
      exp_q.push_back(n);
      tag_q.push_back(t);
   endtask

   task automatic drain();
      while (exp_q.size() > 0) step();
   endtask

   // apply settings from idle/valid state, wait for valid, then score 3 half-periods
   task automatic run_cfg(input int s, input int a, input int b, input string t);
      int n;
      n = half_of(s, a, b);
      sel = 2'(s); da = 6'(a); db = 8'(b);
      while (valid_o) step();
      while (!valid_o) step();
      for (int k = 0; k < 3; k++) push(n, t);
      drain();
   endtask

   // change settings just after an output edge; old half-period must finish unchanged
   task automatic mid_change(input int old_n, input int s, input int a, input int b);
      int   n;
      int   w;
      logic p;
      n = half_of(s, a, b);
      p = clk_o;
      while (clk_o == p) step();
      sel = 2'(s); da = 6'(a); db = 8'(b);
      push(old_n, "R6 old edge");
      push(old_n, "R6 old kept");
      push(n, "R6 new");
      push(n, "R6 new");
      p = clk_o;
      while (clk_o == p) step();
      check("R8 valid cleared on load", int'(valid_o), 0);
      w = 0;
      while (!valid_o) begin
         step();
         w++;
      end
      check("R8 valid rise distance", w, 2*n);
      drain();
   endtask

   initial begin
      repeat (WDOG) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired got %0d exp 0 pending", exp_q.size());
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
   end

   initial begin
      repeat (4) step();
      check("R7 clk_o in reset", int'(clk_o), 0);
      check("R7 valid_o in reset", int'(valid_o), 0);
      rst_n = 1'b1;
      step();
      check("R8 valid low after reset", int'(valid_o), 0);

      run_cfg(0, 0, 0, "R5 bypass div1");
      run_cfg(3, 0, 0, "R1 R5 odd7 bypass");
      run_cfg(0, 63, 0, "R2 first counter 64");
      run_cfg(0, 0, 255, "R3 second counter 256");
      run_cfg(2, 3, 4, "R4 5x4x5");
      run_cfg(1, 1, 2, "R4 3x2x3");
      mid_change(18, 1, 0, 0);
      mid_change(3, 0, 2, 1);
      run_cfg(2, 0, 0, "R1 odd5");

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule